// File: doc/BRIEF.md
# Dual-Clock Stream FIFO

This block moves data words from one clock domain into another whose clock bears no fixed relation to the first. A producer pushes words into it under its own clock, and a consumer drains them in arrival order under a second clock. Storage is a small array with one write port and one read port. Each side keeps its own position counter. The counter holds one more bit than the address needs, so the top bit tells which pass around the array the counter is on. Each counter is re-encoded so that a step changes only one bit. It is then carried into the other domain through a chain of flip-flops. Each side judges its own flag against that delayed copy of the other side's position.

Both data edges follow the valid/ready convention. A word moves on the write side at a rising write clock edge where in_valid and in_ready are both high. Otherwise the producer keeps in_valid and in_data steady, or withdraws them. On the read side, out_data carries the oldest stored word whenever out_valid is high. That word is consumed at a rising read clock edge where out_ready is also high. wr_full and rd_empty are plain status pins and mirror the two handshake signals. Because the other side's position arrives late, either flag can stay raised for a few cycles after the condition has passed. Neither flag ever drops early.

Top module: `xclk_stream_fifo`

## Requirements
- R1: A word offered with in_valid high at a rising wr_clk edge where in_ready is high is stored, and no other word is stored.
- R2: While out_valid is high, out_data is the oldest unread stored word. A rising rd_clk edge with out_valid and out_ready both high removes that word. Words leave in the order they were accepted.
- R3: The array holds DEPTH = 2^ADDR_W words (8 by default). The position counters are ADDR_W+1 bits wide. Starting empty with no reads, exactly DEPTH words are accepted. The number of stored words never exceeds DEPTH.
- R4: Each position counter that crosses domains is kept in reflected Gray form. On any clock edge of its own domain, at most one bit of it changes.
- R5: wr_full is high and in_ready is low once DEPTH unread words are stored. This also holds for the second fill, after the write counter has wrapped.
- R6: While the resets are applied, and right after they are released, rd_empty is 1, out_valid is 0, wr_full is 0 and in_ready is 1. rd_empty is high and out_valid is low whenever every stored word has been read.
- R7: A word offered while wr_full is high is not taken. The write position does not move, and no stored word is altered.
- R8: A read request while rd_empty is high takes nothing, and the read position does not move.
- R9: A flag is never low while its condition holds: wr_full is never low with DEPTH words stored, and rd_empty is never low with none stored. A flag left raised after its condition has cleared falls within six cycles of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, asynchronous, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | DATA_W | Offered word |
| wr_full | output | 1 | All DEPTH slots are taken, as seen by the write side |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, asynchronous, active low |
| out_valid | output | 1 | A stored word is presented |
| out_ready | input | 1 | Consumer takes the presented word |
| out_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | No unread word, as seen by the read side |

## Verification
A push and a pop can fall close together while the array sits near a boundary. The sharp cases are a pop that frees a slot just as the producer presses against a full array, and a push that lands just as the consumer drains the last word. The bench provokes these cases with write and read clocks of 5 ns and 7.4 ns periods, which never settle into a fixed phase. It also runs stretches with both sides enabled at every cycle and mixes of random enable rates. A queue model in the bench judges every presented word and every flag on every cycle of each clock. It also bounds how long a stale flag may stay raised after a slot has changed hands across the domains.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

  // Binary to reflected Gray code; callers cut the result to their width.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary by prefix xor.
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/xfifo_wr_side.sv
module xfifo_wr_side #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [ADDR_W:0]   peer_gray,
  output logic              push,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   gray,
  output logic              full
);

  localparam int PTR_W = ADDR_W + 1;
  // Gray pattern of a pointer one lap ahead: top two bits flipped.
  localparam logic [PTR_W-1:0] LAP_MASK = PTR_W'(3) << (ADDR_W - 1);

  logic [PTR_W-1:0] bin_q, bin_nx, gray_nx;
  logic             full_nx;

  assign push    = push_req & ~full;
  assign bin_nx  = bin_q + PTR_W'(push);
  assign gray_nx = PTR_W'(xfifo_pkg::to_gray(32'(bin_nx)));
  assign full_nx = ((gray_nx ^ peer_gray) == LAP_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
      full  <= 1'b0;
    end else begin
      bin_q <= bin_nx;
      gray  <= gray_nx;
      full  <= full_nx;
    end
  end

  assign addr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/xfifo_rd_side.sv
module xfifo_rd_side #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_req,
  input  logic [ADDR_W:0]   peer_gray,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   gray,
  output logic              empty
);

  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] bin_q, bin_nx, gray_nx;
  logic             pop;

  assign pop     = pop_req & ~empty;
  assign bin_nx  = bin_q + PTR_W'(pop);
  assign gray_nx = PTR_W'(xfifo_pkg::to_gray(32'(bin_nx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
      empty <= 1'b1;
    end else begin
      bin_q <= bin_nx;
      gray  <= gray_nx;
      empty <= (gray_nx == peer_gray);
    end
  end

  assign addr = bin_q[ADDR_W-1:0];

endmodule

// File: rtl/xclk_stream_fifo.sv
module xclk_stream_fifo #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              rd_empty
);

  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  wr_gray, rd_gray, rd_gray_at_w, wr_gray_at_r;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_push;

  xfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .push_req (in_valid),
    .peer_gray(rd_gray_at_w),
    .push     (wr_push),
    .addr     (wr_addr),
    .gray     (wr_gray),
    .full     (wr_full)
  );

  xfifo_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .pop_req  (out_ready),
    .peer_gray(wr_gray_at_r),
    .addr     (rd_addr),
    .gray     (rd_gray),
    .empty    (rd_empty)
  );

  xfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk  (wr_clk),
    .rst_n(wr_rst_n),
    .d    (rd_gray),
    .q    (rd_gray_at_w)
  );

  xfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk  (rd_clk),
    .rst_n(rd_rst_n),
    .d    (wr_gray),
    .q    (wr_gray_at_r)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wclk (wr_clk),
    .we   (wr_push),
    .waddr(wr_addr),
    .wdata(in_data),
    .raddr(rd_addr),
    .rdata(out_data)
  );

  assign in_ready  = ~wr_full;
  assign out_valid = ~rd_empty;

endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int ADDR_W = 3
) (
  input logic            wr_clk,
  input logic            wr_rst_n,
  input logic            rd_clk,
  input logic            rd_rst_n,
  input logic            in_valid,
  input logic            out_ready,
  input logic            wr_full,
  input logic            rd_empty,
  input logic [ADDR_W:0] wgray,
  input logic [ADDR_W:0] rgray
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] wbin, rbin, occ;
  assign wbin = PTR_W'(xfifo_pkg::from_gray(32'(wgray)));
  assign rbin = PTR_W'(xfifo_pkg::from_gray(32'(rgray)));
  assign occ  = wbin - rbin;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && in_valid) |=> $stable(wgray)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && out_ready) |=> $stable(rgray)); // R8
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R4
  AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R4
  AST_OCCUPANCY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
    int'(occ) <= DEPTH); // R3
  AST_FULL_NOT_EARLY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
    !wr_full |-> int'(occ) < DEPTH); // R9
  AST_EMPTY_NOT_EARLY: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
    !rd_empty |-> wgray != rgray); // R9

endmodule

bind xclk_stream_fifo xfifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .in_valid (in_valid),
  .out_ready(out_ready),
  .wr_full  (wr_full),
  .rd_empty (rd_empty),
  .wgray    (wr_gray),
  .rgray    (rd_gray)
);

// File: tb/test_xclk_stream_fifo.sv
`timescale 1ns/1ps
module test_xclk_stream_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, wr_full, out_valid, rd_empty;
  logic [DATA_W-1:0] out_data;

  always #2.5 wr_clk = ~wr_clk;
  always #3.7 rd_clk = ~rd_clk;

  xclk_stream_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_xclk_stream_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .rd_empty(rd_empty)
  );

  int n_chk = 0, n_err = 0;
  int n_push = 0, n_pop = 0;
  int wr_pct = 0, rd_pct = 0;
  int stale_w = 0, stale_r = 0;
  bit running = 1'b0, done = 1'b0;
  logic [DATA_W-1:0] model [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Write side: judge outputs after the last edge, then drive for the next.
  always @(negedge wr_clk) if (running) begin
    if (model.size() == DEPTH)
      check(wr_full === 1'b1 && in_ready === 1'b0, "R5", "full flag with DEPTH stored", int'(wr_full), 1);
    if (in_ready === 1'b1)
      check(model.size() < DEPTH, "R3", "ready while model holds DEPTH", model.size(), DEPTH - 1);
    if (wr_full === 1'b1 && model.size() < DEPTH) stale_w++; else stale_w = 0;
    check(stale_w <= 6, "R9", "stale full cycles", stale_w, 6);
    in_valid = ($urandom_range(99) < wr_pct);
    in_data  = DATA_W'($urandom);
    if (in_valid && in_ready === 1'b1) begin
      model.push_back(in_data); // R1: accepted word joins the queue
      n_push++;
    end
  end

  // Read side: same pattern on the read clock.
  always @(negedge rd_clk) if (running) begin
    if (model.size() == 0)
      check(out_valid === 1'b0 && rd_empty === 1'b1, "R6", "empty flag with nothing stored", int'(out_valid), 0);
    if (out_valid === 1'b1) begin
      if (model.size() == 0)
        check(1'b0, "R8", "word presented while model empty", 1, 0);
      else
        check(out_data === model[0], "R2", "presented word (R1 order)", int'(out_data), int'(model[0]));
    end
    if (out_valid === 1'b0 && model.size() > 0) stale_r++; else stale_r = 0;
    check(stale_r <= 6, "R9", "stale empty cycles", stale_r, 6);
    out_ready = ($urandom_range(99) < rd_pct);
    if (out_ready && out_valid === 1'b1 && model.size() > 0) begin
      void'(model.pop_front());
      n_pop++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge wr_clk);
    check(rd_empty === 1'b1 && out_valid === 1'b0, "R6", "empty during reset", int'(rd_empty), 1);
    check(wr_full === 1'b0 && in_ready === 1'b1, "R6", "not full during reset", int'(wr_full), 0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    #0.5;
    check(rd_empty === 1'b1 && out_valid === 1'b0, "R6", "empty after release", int'(out_valid), 0);
    check(wr_full === 1'b0 && in_ready === 1'b1, "R6", "ready after release", int'(in_ready), 1);
    running = 1'b1;

    // First fill, no reads: exactly DEPTH accepted, then pressing on full.
    wr_pct = 100; rd_pct = 0;
    repeat (30) @(negedge wr_clk);
    check(n_push == DEPTH, "R3", "words accepted on first fill", n_push, DEPTH);
    check(in_ready === 1'b0 && wr_full === 1'b1, "R5", "full after first fill", int'(wr_full), 1);
    repeat (10) @(negedge wr_clk);
    check(n_push == DEPTH, "R7", "writes while full ignored", n_push, DEPTH);

    // Drain with read requested past empty.
    wr_pct = 0; rd_pct = 100;
    repeat (40) @(negedge rd_clk);
    check(n_pop == DEPTH, "R2", "words read after drain", n_pop, DEPTH);
    check(out_valid === 1'b0 && rd_empty === 1'b1, "R6", "empty after drain", int'(rd_empty), 1);
    repeat (10) @(negedge rd_clk);
    check(n_pop == DEPTH && out_valid === 1'b0, "R8", "reads while empty ignored", n_pop, DEPTH);

    // Second fill wraps the write counter.
    rd_pct = 0; wr_pct = 100;
    repeat (30) @(negedge wr_clk);
    check(n_push == 2 * DEPTH, "R5", "words accepted on wrapped fill", n_push, 2 * DEPTH);
    check(wr_full === 1'b1, "R5", "full after wrap", int'(wr_full), 1);
    wr_pct = 0; rd_pct = 100;
    repeat (40) @(negedge rd_clk);
    check(n_pop == 2 * DEPTH, "R2", "words read after second drain", n_pop, 2 * DEPTH);

    // Both sides busy together, then mixed rates.
    wr_pct = 100; rd_pct = 100;
    repeat (500) @(negedge wr_clk);
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin wr_pct = 80; rd_pct = 30; end
        1: begin wr_pct = 30; rd_pct = 80; end
        2: begin wr_pct = 50; rd_pct = 50; end
        default: begin wr_pct = 95; rd_pct = 90; end
      endcase
      repeat (800) @(negedge wr_clk);
    end

    // Final drain.
    wr_pct = 0; rd_pct = 100;
    repeat (60) @(negedge rd_clk);
    check(n_pop == n_push, "R2", "all accepted words delivered", n_pop, n_push);
    check(out_valid === 1'b0, "R6", "empty at end", int'(out_valid), 0);
    check(n_push > 4 * DEPTH, "R1", "traffic accepted in mixed phase", n_push, 4 * DEPTH + 1);

    done = 1'b1;
    running = 1'b0;
    summary();
    $finish;
  end

endmodule